// File: doc/BRIEF.md
# SPI Slave Serial Front-End with Pause

This block is the serial edge of an SPI slave memory. It runs entirely in a fast system clock and oversamples the chip-select, serial clock, serial data in and pause inputs. Each input passes through its own synchroniser. Rising and falling serial-clock edges are found by comparing successive synchronised samples. Only SPI modes 0 and 3 are handled: data is sampled on a rising edge and the output changes on a falling edge.

Incoming bits are gathered most significant bit first. After every eighth accepted bit the block presents the byte to the command layer with a one-cycle strobe. At that same strobe it takes the next outgoing byte from the command layer and shifts it out, MSB first, starting at the following falling edge. It reports chip-select edges and the pause state. The command layer can silence the block for the rest of a transaction when it finds an invalid opcode.

A pause input lets the host freeze a transfer without losing its place. The pause engages or releases only while the serial clock is low. While paused, the output is floated and serial clock edges are ignored. Command decoding, the storage array and the status bits belong to the command layer.

Top module: `spi_slave_front`

## Requirements
- R1: Received bytes are assembled MSB first; `rxValid` pulses high for exactly one system cycle after the eighth accepted rising SCK edge, with the full byte on `rxByte` in that cycle.
- R2: `txByte` is captured in the cycle `rxValid` is high; its bit 7 appears on `soOut` after the next falling SCK edge, and each later falling edge moves to the next lower bit; `soOe` is high while the block is selected, not paused and not silenced.
- R3: While `csN` is high, SI and SCK activity produce no received byte and `soOe` stays low.
- R4: `holdActive` can rise or fall only while SCK is low; a change of the pause input while SCK is high has no effect until SCK goes low.
- R5: While paused, `soOe` is low and SCK edges neither sample SI nor advance the bit position; after release the byte continues from the bit where it stopped.
- R6: After `abortReq` is pulsed during a transaction, `soOe` stays low and no byte is reported until the next falling edge of `csN`; the transaction after that works normally.
- R7: A falling edge of `csN` resets the bit position, so a partial byte from an earlier transaction is discarded.
- R8: `csFall` and `csRise` each pulse once per falling and rising edge of `csN`.
- R9: Transfers work with SCK idling low (mode 0) and with SCK idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the SCK rate |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| holdN | input | 1 | Pause request, active low |
| abortReq | input | 1 | Command layer silences the rest of the transaction |
| txByte | input | 8 | Next byte to transmit, captured at each `rxValid` |
| rxByte | output | 8 | Received byte, valid while `rxValid` is high |
| rxValid | output | 1 | One-cycle byte strobe |
| csFall | output | 1 | One-cycle strobe on chip-select assertion |
| csRise | output | 1 | One-cycle strobe on chip-select release |
| holdActive | output | 1 | Transfer is paused |
| soOut | output | 1 | Serial data out value |
| soOe | output | 1 | Output enable for the serial data out driver |

## Verification
Assertions check the following on every cycle: the byte strobe is always a single pulse, the pause state changes only while the synchronised SCK is low, the bit position holds still while paused, and it is cleared after every chip-select assertion. Only the bench scenarios show end-to-end behaviour. These cover MSB-first assembly and transmission in both modes, a byte resuming correctly after a pause with SCK toggling, SI being ignored while deselected, and silence after an abort with recovery on the next transaction.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic clear;    // chip-select just asserted: flush shifters
    logic sample;   // accept SI on this rising SCK edge
    logic lastBit;  // the sample completes a byte
    logic shiftOut; // advance the output on this falling SCK edge
  } ctrlStrobeT;

  localparam logic [3:0] SYNC_RESET = 4'b1001; // {cs, sck, si, hold}
endpackage

// File: rtl/spi_front_sync.sv
module spi_front_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= dIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[g] <= RST_VAL;
      else       stg[g] <= stg[g-1];
    end
  end

  assign dOut = stg[STAGES-1];
endmodule

// File: rtl/spi_front_ctrl.sv
module spi_front_ctrl
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       holdS,
  input  logic       abortReq,
  output ctrlStrobeT st,
  output logic       csFall,
  output logic       csRise,
  output logic       paused,
  output logic       soOe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             csPrev;
  logic             sckPrev;
  logic             aborted;
  logic [CNT_W-1:0] bitCnt;
  logic             selected;
  logic             active;
  logic             sckRise;
  logic             sckFall;

  assign selected = !csS;
  assign csFall   = csPrev && !csS;
  assign csRise   = !csPrev && csS;
  assign sckRise  = sckS && !sckPrev;
  assign sckFall  = !sckS && sckPrev;
  assign active   = selected && !paused && !(aborted && !csFall);

  assign st.clear    = csFall;
  assign st.sample   = active && sckRise;
  assign st.lastBit  = (bitCnt == LAST);
  assign st.shiftOut = active && sckFall;
  assign soOe        = selected && !paused && !aborted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  // Bit position: cleared at selection, frozen unless sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (csFall)    bitCnt <= '0;
    else if (st.sample) bitCnt <= st.lastBit ? '0 : bitCnt + 1'b1;
  end

  // Pause follows the hold input, but only while SCK is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          paused <= 1'b0;
    else if (!selected) paused <= 1'b0;
    else if (!sckS)     paused <= !holdS;
  end

  // Silence until the next selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     aborted <= 1'b0;
    else if (csFall)               aborted <= 1'b0;
    else if (selected && abortReq) aborted <= 1'b1;
  end

  AST_PAUSE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (paused != $past(paused)) && !$past(csS) |-> !$past(sckS)); // R4

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    paused |=> $stable(bitCnt)); // R5

  AST_SELECT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (bitCnt == '0)); // R7
endmodule

// File: rtl/spi_front_dp.sv
module spi_front_dp
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        st,
  input  logic              siS,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              soBit
);
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxValid <= 1'b0;
    end else if (st.clear) begin
      rxShift <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= st.sample && st.lastBit;
      if (st.sample) rxShift <= {rxShift[DATA_W-2:0], siS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      soBit   <= 1'b0;
    end else if (st.clear) begin
      txShift <= '0;
      soBit   <= 1'b0;
    end else if (rxValid) begin
      txShift <= txByte;
    end else if (st.shiftOut) begin
      {soBit, txShift} <= {txShift, 1'b0};
    end
  end

  assign rxByte = rxShift;

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R1
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
  import spi_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              abortReq,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              csFall,
  output logic              csRise,
  output logic              holdActive,
  output logic              soOut,
  output logic              soOe
);
  logic [3:0] syncOut;
  ctrlStrobeT st;

  spi_front_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RESET)) uSync (
    .clk(clk), .rstN(rstN),
    .dIn({csN, sck, si, holdN}),
    .dOut(syncOut)
  );

  spi_front_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .csS(syncOut[3]), .sckS(syncOut[2]), .holdS(syncOut[0]),
    .abortReq(abortReq),
    .st(st), .csFall(csFall), .csRise(csRise),
    .paused(holdActive), .soOe(soOe)
  );

  spi_front_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN),
    .st(st), .siS(syncOut[1]), .txByte(txByte),
    .rxByte(rxByte), .rxValid(rxValid), .soBit(soOut)
  );
endmodule

// File: tb/spi_slave_front_bench.sv
module spi_slave_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4; // system cycles per SCK half period

  logic clk = 0, rstN = 0, csN = 1, sck = 0, si = 0, holdN = 1, abortReq = 0;
  logic [7:0] txByte = 8'h00;
  logic [7:0] rxByte;
  logic rxValid, csFall, csRise, holdActive, soOut, soOe;

  int checks = 0, errors = 0, rxCnt = 0, fallCnt = 0, riseCnt = 0;
  bit idleHigh = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_front u_spi_slave_front (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .abortReq(abortReq), .txByte(txByte), .rxByte(rxByte), .rxValid(rxValid),
    .csFall(csFall), .csRise(csRise), .holdActive(holdActive),
    .soOut(soOut), .soOe(soOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (csFall) fallCnt++;
      if (csRise) riseCnt++;
      if (rxValid) begin
        rxCnt++;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R1/R3/R6 unexpected byte actual=%0h expected=none", rxByte);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (rxByte !== e) begin
            errors++;
            $display("FAIL R1 byte actual=%0h expected=%0h", rxByte, e);
          end
        end
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input bit chkSo, input logic expBit, input string req);
    sck = 0; si = b;
    waitCyc(HALF);
    if (chkSo) chk(soOut === expBit && soOe === 1'b1, req, {soOe, soOut}, {1'b1, expBit});
    sck = 1;
    waitCyc(HALF);
  endtask

  task automatic xferByte(input logic [7:0] mo, input bit push, input bit chkSo,
                          input logic [7:0] expSo, input string req);
    if (push) expQ.push_back(mo);
    for (int i = 7; i >= 0; i--) sendBit(mo[i], chkSo, expSo[i], req);
  endtask

  task automatic csLow();
    sck = idleHigh;
    waitCyc(HALF);
    csN = 0;
    waitCyc(2*HALF);
  endtask

  task automatic csHigh();
    waitCyc(HALF);
    sck = idleHigh;
    waitCyc(HALF);
    csN = 1;
    waitCyc(2*HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0, r0, n0;
    waitCyc(3);
    rstN = 1;
    waitCyc(3);
    // Reset state
    chk(soOe === 1'b0, "R3 reset soOe", soOe, 0);
    chk(rxValid === 1'b0, "R1 reset rxValid", rxValid, 0);
    chk(holdActive === 1'b0, "R4 reset holdActive", holdActive, 0);

    // Mode 0 transfer with transmit data (R1 R2 R8 R9)
    idleHigh = 0;
    f0 = fallCnt; r0 = riseCnt;
    csLow();
    chk(fallCnt == f0 + 1, "R8 csFall count", fallCnt, f0 + 1);
    txByte = 8'h96;
    xferByte(8'h3C, 1, 0, 8'h00, "R2");
    chk(soOe === 1'b1, "R2 soOe selected", soOe, 1);
    txByte = 8'h00;
    xferByte(8'hA5, 1, 1, 8'h96, "R2 mode0 SO bit");
    csHigh();
    chk(riseCnt == r0 + 1, "R8 csRise count", riseCnt, r0 + 1);

    // Mode 3 transfer (R9)
    idleHigh = 1;
    csLow();
    txByte = 8'h69;
    xferByte(8'hC3, 1, 0, 8'h00, "R9");
    txByte = 8'h00;
    xferByte(8'h5A, 1, 1, 8'h69, "R9 mode3 SO bit");
    csHigh();
    idleHigh = 0;

    // Deselected activity is ignored (R3)
    n0 = rxCnt;
    for (int i = 0; i < 8; i++) begin
      si = i[0]; sck = 0; waitCyc(HALF);
      chk(soOe === 1'b0, "R3 soOe while deselected", soOe, 0);
      sck = 1; waitCyc(HALF);
    end
    sck = 0; waitCyc(2*HALF);
    chk(rxCnt == n0, "R3 no byte while deselected", rxCnt, n0);

    // Partial byte discarded by reselection (R7)
    csLow();
    sendBit(1, 0, 0, ""); sendBit(1, 0, 0, ""); sendBit(0, 0, 0, "");
    csHigh();
    csLow();
    n0 = rxCnt;
    xferByte(8'h81, 1, 0, 8'h00, "R7");
    waitCyc(2);
    chk(rxCnt == n0 + 1, "R7 byte after reselect", rxCnt, n0 + 1);
    csHigh();

    // Pause mid-byte with SCK toggling (R4 R5)
    csLow();
    expQ.push_back(8'hB4);
    sendBit(1, 0, 0, ""); sendBit(0, 0, 0, ""); sendBit(1, 0, 0, ""); sendBit(1, 0, 0, "");
    holdN = 0; waitCyc(HALF);
    chk(holdActive === 1'b0, "R4 no pause while SCK high", holdActive, 0);
    sck = 0; waitCyc(HALF);
    chk(holdActive === 1'b1, "R4 pause engages SCK low", holdActive, 1);
    chk(soOe === 1'b0, "R5 soOe during pause", soOe, 0);
    n0 = rxCnt;
    for (int i = 0; i < 3; i++) begin
      sck = 1; si = ~si; waitCyc(HALF);
      sck = 0; waitCyc(HALF);
    end
    sck = 1; waitCyc(HALF);
    holdN = 1; waitCyc(HALF);
    chk(holdActive === 1'b1, "R4 no release while SCK high", holdActive, 1);
    sck = 0; waitCyc(HALF);
    chk(holdActive === 1'b0, "R4 release SCK low", holdActive, 0);
    chk(soOe === 1'b1, "R5 soOe after release", soOe, 1);
    sendBit(0, 0, 0, ""); sendBit(1, 0, 0, ""); sendBit(0, 0, 0, ""); sendBit(0, 0, 0, "");
    waitCyc(2);
    chk(rxCnt == n0 + 1, "R5 byte resumes after pause", rxCnt, n0 + 1);
    csHigh();

    // Abort silences until next selection (R6)
    csLow();
    xferByte(8'hFF, 1, 0, 8'h00, "R6");
    abortReq = 1; waitCyc(1); abortReq = 0;
    waitCyc(1);
    chk(soOe === 1'b0, "R6 soOe after abort", soOe, 0);
    n0 = rxCnt;
    xferByte(8'h12, 0, 0, 8'h00, "R6");
    waitCyc(2);
    chk(rxCnt == n0, "R6 no byte after abort", rxCnt, n0);
    chk(soOe === 1'b0, "R6 soOe stays low", soOe, 0);
    csHigh();
    csLow();
    chk(soOe === 1'b1, "R6 soOe restored", soOe, 1);
    xferByte(8'h34, 1, 0, 8'h00, "R6");
    waitCyc(2);
    chk(rxCnt == n0 + 1, "R6 byte after reselect", rxCnt, n0 + 1);
    csHigh();

    chk(expQ.size() == 0, "R1 all expected bytes seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule